// File: doc/BRIEF.md
# Audio Serial Output Formatter

This block puts a pair of 20-bit two's-complement audio samples onto a single serial data line. It is a follower: the bit clock and the frame clock both come from outside, and the block only decides which bit appears in each bit period. Two framings are offered. In the left-justified framing the frame clock is high for the left channel and the word starts at once. In the I2S-compatible framing the frame clock is low for the left channel and the word starts one bit period late.

Ahead of serialization a monaural stage can replace the pair. It can send the average of both channels, the left channel twice or the right channel twice. Each pair is captured at the start of the left half-frame, so both halves of one frame come from the same pair.

When the reset pin is low the line is held at zero. After the pin is released the line stays at zero for a set number of frames, the calibration window. Real samples appear only after that window.

Top module: `aud_ser_fmt`

## Requirements
- R1: The frame clock is sampled on every falling bit-clock edge. The falling edge at which a new frame level is first seen starts bit period 0 of that half-frame. With fmt_i = 0, frame_i = 1 marks the left half and frame_i = 0 the right half. The word's bits 19 down to 0 appear in bit periods 0 to 19, MSB first.
- R2: With fmt_i = 1, frame_i = 0 marks the left half and frame_i = 1 the right half. Bits 19 down to 0 appear in bit periods 1 to 20. Period 0 carries the LSB of the previous half's word when that half lasted exactly 20 bit periods, and 0 otherwise.
- R3: Every bit period after the last word bit carries 0. That is period 20 onward with fmt_i = 0, and period 21 onward with fmt_i = 1.
- R4: sd_o changes only at falling edges of the bit clock. It is stable from one rising edge to the next falling edge.
- R5: With mono_i = 00, the left half carries left_i and the right half carries right_i.
- R6: With mono_i = 01, both halves carry floor((left_i + right_i) / 2), formed as a 21-bit signed sum shifted right by one with the sign kept. For example, 7FFFF and 7FFFF give 7FFFF, 80000 and 80000 give 80000, 00001 and 00000 give 00000, and FFFFF and 00000 give FFFFF.
- R7: With mono_i = 10, both halves carry left_i. With mono_i = 11, both halves carry right_i.
- R8: left_i and right_i are sampled at the falling edge that starts the left half. A change to them later in that frame does not alter either half of that frame.
- R9: After rst_n_i rises, the first falling edge never counts as a frame edge. The first CAL_FRAMES frames, counted by left-half starts, carry all-zero data on both halves, and the next frame carries real data.
- R10: While rst_n_i is low, sd_o is 0. It falls to 0 as soon as rst_n_i goes low, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; output bits launch on its falling edge |
| rst_n_i | input | 1 | Reset pin, active low, asynchronous |
| frame_i | input | 1 | Frame clock; its level selects the channel |
| fmt_i | input | 1 | Framing: 0 left-justified, 1 I2S-compatible |
| mono_i | input | 2 | Mix: 00 stereo, 01 average, 10 left twice, 11 right twice |
| left_i | input | SW | Left-channel sample, two's complement |
| right_i | input | SW | Right-channel sample, two's complement |
| sd_o | output | 1 | Serial data line |

## Verification
The bench builds the block with SW = 20 and CAL_FRAMES = 3. With a window that short, the bench can see the line leave the forced-zero window and then, after a second reset pulse in mid-frame, enter it again, all within a few thousand bit clocks. Half-frames of 20, 24 and 32 bit periods are used. The 20-period case in the I2S-compatible framing is what makes the LSB spill into the next half's first period visible.

// File: rtl/aud_ser_fmt.sv
module aud_ser_fmt #(
  parameter int SW = 20,
  parameter int CAL_FRAMES = 4128
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          frame_i,
  input  logic          fmt_i,
  input  logic [1:0]    mono_i,
  input  logic [SW-1:0] left_i,
  input  logic [SW-1:0] right_i,
  output logic          sd_o
);
  localparam int CW = $clog2(CAL_FRAMES + 1);
  localparam logic [CW-1:0] CAL_LAST = CW'(CAL_FRAMES);

  logic          armed, frame_q;
  logic [CW-1:0] cal_cnt;
  logic [SW-1:0] hold_r, sr;
  logic [SW-1:0] mix_l, mix_r, avg, word;
  logic signed [SW:0] sum;

  wire edge_w   = armed & (frame_i ^ frame_q);
  wire left_w   = frame_i ^ fmt_i;
  wire cal_busy = (cal_cnt != CAL_LAST);

  assign sum = $signed({left_i[SW-1], left_i}) + $signed({right_i[SW-1], right_i});
  assign avg = SW'(sum >>> 1);

  always_comb begin
    case (mono_i)
      2'b01:   begin mix_l = avg;     mix_r = avg;     end
      2'b10:   begin mix_l = left_i;  mix_r = left_i;  end
      2'b11:   begin mix_l = right_i; mix_r = right_i; end
      default: begin mix_l = left_i;  mix_r = right_i; end
    endcase
  end

  assign word = left_w ? (cal_busy ? '0 : mix_l) : hold_r;

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      armed   <= 1'b0;
      frame_q <= 1'b0;
      cal_cnt <= '0;
      hold_r  <= '0;
      sr      <= '0;
      sd_o    <= 1'b0;
    end else begin
      armed   <= 1'b1;
      frame_q <= frame_i;
      if (edge_w) begin
        if (left_w) begin
          hold_r <= cal_busy ? '0 : mix_r;
          if (cal_busy) cal_cnt <= cal_cnt + CW'(1);
        end
        if (!fmt_i) begin
          sd_o <= word[SW-1];
          sr   <= {word[SW-2:0], 1'b0};
        end else begin
          sd_o <= sr[SW-1];
          sr   <= word;
        end
      end else begin
        sd_o <= sr[SW-1];
        sr   <= {sr[SW-2:0], 1'b0};
      end
    end
  end
endmodule

module aud_ser_fmt_chk #(
  parameter int SW = 20,
  parameter int CAL_FRAMES = 4128
) (
  input logic clk_i,
  input logic rst_n_i,
  input logic frame_i,
  input logic fmt_i,
  input logic sd_o
);
  localparam int LW = $clog2(CAL_FRAMES + 2);
  localparam logic [LW-1:0] CAL_L = LW'(CAL_FRAMES);
  localparam int PW = $clog2(SW + 2);
  localparam logic [PW-1:0] POS_TOP = PW'(SW + 1);
  localparam logic [PW-1:0] POS_SW = PW'(SW);

  logic          armed_c, fq_c, sd_pos;
  logic [LW-1:0] lc;
  logic [PW-1:0] pos;
  wire edge_c = armed_c & (frame_i ^ fq_c);

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      armed_c <= 1'b0;
      fq_c    <= 1'b0;
      lc      <= '0;
      pos     <= '0;
    end else begin
      armed_c <= 1'b1;
      fq_c    <= frame_i;
      if (edge_c) pos <= '0;
      else if (pos != POS_TOP) pos <= pos + PW'(1);
      if (edge_c && (frame_i ^ fmt_i) && lc <= CAL_L) lc <= lc + LW'(1);
    end
  end

  always_ff @(posedge clk_i) sd_pos <= sd_o;

  always @(posedge clk_i) begin
    if (!rst_n_i) assert_quiet_in_reset_R10: assert (sd_o == 1'b0);
  end

  assert_cal_zero_R9: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (lc <= CAL_L) |-> (sd_o == 1'b0));

  assert_tail_zero_R3: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (pos > POS_SW) |-> (sd_o == 1'b0));

  assert_fall_only_R4: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (sd_o == sd_pos));
endmodule

bind aud_ser_fmt aud_ser_fmt_chk #(.SW(SW), .CAL_FRAMES(CAL_FRAMES)) u_chk (
  .clk_i(clk_i), .rst_n_i(rst_n_i), .frame_i(frame_i), .fmt_i(fmt_i), .sd_o(sd_o));

// File: tb/aud_ser_fmt_tb.sv
`timescale 1ns/1ps
module aud_ser_fmt_tb;
  localparam int SW = 20;
  localparam int CAL = 3;

  logic clk_i = 1'b0, rst_n_i = 1'b0, frame_i = 1'b0, fmt_i = 1'b0;
  logic [1:0] mono_i = 2'b00;
  logic [SW-1:0] left_i = '0, right_i = '0;
  logic sd_o;

  int total = 0, bad = 0, cal_seen = 0, prev_h = 32;
  bit in_rst = 1'b1, done = 1'b0;
  logic [SW-1:0] prev_w = '0;

  aud_ser_fmt #(.SW(SW), .CAL_FRAMES(CAL)) u_dut (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .frame_i(frame_i), .fmt_i(fmt_i),
    .mono_i(mono_i), .left_i(left_i), .right_i(right_i), .sd_o(sd_o));

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] mixw(input logic [SW-1:0] l, input logic [SW-1:0] r,
                                         input logic [1:0] m, input bit rside);
    logic signed [SW:0] s;
    s = $signed({l[SW-1], l}) + $signed({r[SW-1], r});
    case (m)
      2'b01:   mixw = SW'(s >>> 1);
      2'b10:   mixw = l;
      2'b11:   mixw = r;
      default: mixw = rside ? r : l;
    endcase
  endfunction

  function automatic logic [63:0] expv(input bit f, input int h, input logic [SW-1:0] w, input logic spill);
    logic [63:0] e;
    e = '0;
    for (int i = 0; i < h; i++) begin
      if (!f) e[i] = (i < SW) ? w[SW-1-i] : 1'b0;
      else if (i == 0) e[i] = spill;
      else e[i] = (i <= SW) ? w[SW-i] : 1'b0;
    end
    return e;
  endfunction

  task automatic step(output logic b, output int g);
    @(posedge clk_i);
    b = sd_o;
    #2;
    g = (sd_o !== b) ? 1 : 0;
  endtask

  task automatic run_frame(input int h, input logic [SW-1:0] l, input logic [SW-1:0] r,
                           input bit scr, input string tag);
    logic [63:0] cl, cr, el, er;
    logic [SW-1:0] wl, wr;
    logic b;
    int g, gl;
    bit z;
    z  = in_rst || (cal_seen < CAL);
    wl = z ? '0 : mixw(l, r, mono_i, 1'b0);
    wr = z ? '0 : mixw(l, r, mono_i, 1'b1);
    el = expv(fmt_i, h, wl, (!in_rst && prev_h == SW) ? prev_w[0] : 1'b0);
    er = expv(fmt_i, h, wr, (h == SW) ? wl[0] : 1'b0);
    if (in_rst) begin el = '0; er = '0; end
    cl = '0; cr = '0; gl = 0;
    frame_i = ~fmt_i; left_i = l; right_i = r;
    for (int i = 0; i < h; i++) begin
      step(b, g); cl[i] = b; gl += g;
      if (scr && i == 3) begin left_i = ~l; right_i = ~r; end
    end
    frame_i = fmt_i;
    for (int i = 0; i < h; i++) begin
      step(b, g); cr[i] = b; gl += g;
    end
    chk(cl === el, {tag, " left half"}, cl, el);
    chk(cr === er, {tag, " right half"}, cr, er);
    chk(gl == 0, "R4 mid-period change", 64'(gl), 64'd0);
    if (!in_rst) cal_seen++;
    prev_w = in_rst ? '0 : wr;
    prev_h = h;
  endtask

  task automatic idle(input int n);
    logic b;
    int g;
    for (int i = 0; i < n; i++) step(b, g);
  endtask

  task automatic release_rst();
    rst_n_i = 1'b1; in_rst = 1'b0; cal_seen = 0; prev_w = '0; prev_h = 32;
    idle(1);
  endtask

  task automatic switch_fmt(input bit f);
    fmt_i = f; frame_i = f;
    idle(32);
    prev_h = 32;
  endtask

  task automatic t_reset();
    chk(sd_o === 1'b0, "R10 reset state", 64'(sd_o), 64'd0);
    run_frame(32, 20'h12345, 20'h54321, 1'b0, "R10");
  endtask

  task automatic t_cal();
    release_rst();
    for (int k = 0; k < CAL; k++) run_frame(32, 20'hA5A5A, 20'h3C3C3, 1'b0, "R9");
    run_frame(32, 20'hA5A5A, 20'h3C3C3, 1'b0, "R9 R1 first data");
  endtask

  task automatic t_lj();
    run_frame(32, 20'h80001, 20'h7FFFE, 1'b0, "R5 R1");
    run_frame(24, 20'hFFFFF, 20'hFFFFF, 1'b0, "R3");
    run_frame(20, 20'h00001, 20'hC0003, 1'b0, "R1 twenty");
  endtask

  task automatic t_latch();
    run_frame(32, 20'h12345, 20'hFEDCB, 1'b1, "R8");
  endtask

  task automatic t_mono();
    mono_i = 2'b01;
    run_frame(32, 20'h7FFFF, 20'h7FFFF, 1'b0, "R6 max");
    run_frame(32, 20'h80000, 20'h80000, 1'b0, "R6 min");
    run_frame(32, 20'h00001, 20'h00000, 1'b0, "R6 floor pos");
    run_frame(32, 20'hFFFFF, 20'h00000, 1'b0, "R6 floor neg");
    mono_i = 2'b10;
    run_frame(32, 20'h9ABCD, 20'h13579, 1'b0, "R7 left");
    mono_i = 2'b11;
    run_frame(32, 20'h9ABCD, 20'h13579, 1'b0, "R7 right");
    mono_i = 2'b00;
  endtask

  task automatic t_i2s();
    switch_fmt(1'b1);
    run_frame(32, 20'hB1234, 20'h4DCBA, 1'b0, "R2");
    run_frame(20, 20'h00001, 20'h80001, 1'b0, "R2 twenty");
    run_frame(20, 20'hFFFFF, 20'h00003, 1'b0, "R2 spill");
    run_frame(32, 20'h55555, 20'hAAAAA, 1'b0, "R2 R3 spill");
    mono_i = 2'b01;
    run_frame(32, 20'h7FFFF, 20'h80000, 1'b0, "R6 i2s");
    mono_i = 2'b00;
  endtask

  task automatic t_midrst();
    logic b;
    int g;
    switch_fmt(1'b0);
    frame_i = 1'b1; left_i = 20'hFFFFF; right_i = '0;
    for (int i = 0; i < 5; i++) step(b, g);
    chk(b === 1'b1, "R1 bit before reset", 64'(b), 64'd1);
    rst_n_i = 1'b0; in_rst = 1'b1;
    #0.2;
    chk(sd_o === 1'b0, "R10 async clear", 64'(sd_o), 64'd0);
    idle(3);
    frame_i = 1'b0;
    idle(4);
    release_rst();
    for (int k = 0; k < CAL; k++) run_frame(32, 20'h6789A, 20'h2468A, 1'b0, "R9 again");
    run_frame(32, 20'h6789A, 20'h2468A, 1'b0, "R9 R1 data again");
  endtask

  initial begin
    idle(2);
    t_reset();
    t_cal();
    t_lj();
    t_latch();
    t_mono();
    t_i2s();
    t_midrst();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule